// File: doc/BRIEF.md
# Multi-Channel Input Delay Calibration Controller

This controller aligns several copies of one serial input stream, each of which reaches its own deserializer through a tap-programmable delay line. After a start request it clears every delay line to tap zero. It then works through the channels one after another. For the channel under test it steps the delay one tap at a time and checks the captured bytes against a fixed training byte. It records the first tap at which the capture goes wrong.

Once every channel has been measured, the smallest recorded tap among the channels that produced a result is taken as the common reference. Each channel's offset from that reference then gets a staggered phase delay of one fixed tap step per channel index, so channel 0 gets none, channel 1 one step, and so on. The results are clamped to the last tap and loaded into all delay lines in a single cycle. The final taps, the per-channel error flags and a done flag stay valid until the next start.

Top module: `dcal_ctrl`

## Requirements
- R1: A one-cycle `start_i` pulse seen while idle or done produces a one-cycle `dly_rst_o` pulse, which returns every delay line to tap 0. It also clears `done_o`, `cal_err_o` and `tap_set_o`.
- R2: Channels are measured strictly in ascending index order. `dly_inc_o` is one-hot or zero, and each pulse on bit c advances channel c by exactly one tap.
- R3: After each tap change the first `SETTLE_CYC` captured bytes are ignored. The next `CMP_BYTES` bytes are compared. Two back-to-back increments of the same channel are therefore exactly `SETTLE_CYC + CMP_BYTES` cycles apart (12 by default).
- R4: The byte compared for channel c is `cap_data_i[8c+7:8c]`, checked against `TRAIN_PATTERN` (default 8'hA5). A single mismatching byte in the compare window counts as a failure. The channel's recorded tap is the tap at which it first fails, so it receives exactly that many increments.
- R5: A channel that has not failed once tap 63 has been compared gets its bit in `cal_err_o` set and an alignment offset of 0. It receives 63 increments.
- R6: The reference tap is the minimum recorded tap over the channels without an error. If every channel has an error, the reference is 0. Each channel's alignment offset is its recorded tap minus the reference.
- R7: Channel c's final tap is its alignment offset plus c × `PHASE_STEP` taps (default 5 taps, about 45 degrees of the data period), clamped to 63.
- R8: The final taps are presented on `tap_set_o` while `dly_load_o` is all ones for exactly one cycle. `done_o` rises in the following cycle.
- R9: `done_o`, `tap_set_o` and `cal_err_o` hold until the next accepted start. A start during calibration is ignored and does not change the result.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Calibration request pulse |
| cap_data_i | input | NUM_CH*DATA_W | Deserialized byte of each channel, channel c in bits [8c+7:8c] |
| dly_rst_o | output | 1 | Return all delay lines to tap 0 |
| dly_inc_o | output | NUM_CH | Per-channel one-tap increment pulse |
| dly_load_o | output | NUM_CH | Per-channel load of `tap_set_o` |
| tap_set_o | output | NUM_CH*TAP_W | Final tap per channel, channel c in bits [6c+5:6c] |
| cal_err_o | output | NUM_CH | Channel never failed across the tap range |
| done_o | output | 1 | Calibration finished, results valid |

## Verification
The assertions rely on `start_i` being a pulse of a single cycle. They also rely on the delay lines following the controller's reset, increment and load commands, so that no tap changes except through those commands. The bench drives start only as one-cycle pulses. It models each delay line as a counter that reacts only to those three commands. For each channel it corrupts the captured byte on every third cycle once the line reaches that channel's failing tap. This guarantees that a four-byte compare window catches the failure even though single bytes still match.

// File: rtl/dcal_pkg.sv
package dcal_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_CLEAR   = 3'd1,
      ST_MEASURE = 3'd2,
      ST_NORM    = 3'd3,
      ST_LOAD    = 3'd4,
      ST_DONE    = 3'd5
   } dcal_state_e;

endpackage

// File: rtl/dcal_window.sv
// Settle-then-compare timing window, restarted after every tap change.
module dcal_window #(
   parameter int SETTLE_CYC = 8,
   parameter int CMP_BYTES  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   output logic in_cmp_o,
   output logic last_o
);
   localparam int TOTAL = SETTLE_CYC + CMP_BYTES;
   localparam int CNT_W = $clog2(TOTAL);

   generate
      if (SETTLE_CYC < 1 || CMP_BYTES < 1) begin : g_bad_window
         $error("dcal_window: SETTLE_CYC and CMP_BYTES must be at least 1");
      end
   endgenerate

   logic             active_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (restart_i) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
      end else if (active_q) begin
         if (cnt_q == CNT_W'(TOTAL - 1)) begin
            active_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign in_cmp_o = active_q && (cnt_q >= CNT_W'(SETTLE_CYC));
   assign last_o   = active_q && (cnt_q == CNT_W'(TOTAL - 1));

endmodule

// File: rtl/dcal_match.sv
// Compares each channel's captured byte with the training byte and
// accumulates a sticky failure for the selected channel.
module dcal_match #(
   parameter int                NUM_CH        = 4,
   parameter int                DATA_W        = 8,
   parameter logic [DATA_W-1:0] TRAIN_PATTERN = 8'hA5,
   localparam int               CH_W          = $clog2(NUM_CH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH*DATA_W-1:0] data_i,
   input  logic [CH_W-1:0]          sel_i,
   input  logic                     sample_i,
   input  logic                     clear_i,
   output logic                     hit_o
);
   logic [NUM_CH-1:0] miss;
   logic              miss_sel;
   logic              fail_q;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
         assign miss[c] = data_i[c*DATA_W +: DATA_W] != TRAIN_PATTERN;
      end
   endgenerate

   assign miss_sel = sample_i && miss[sel_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail_q <= 1'b0;
      end else if (clear_i) begin
         fail_q <= 1'b0;
      end else if (miss_sel) begin
         fail_q <= 1'b1;
      end
   end

   assign hit_o = fail_q | miss_sel;

endmodule

// File: rtl/dcal_normalize.sv
// Subtracts the common reference tap and adds the staggered phase step.
module dcal_normalize #(
   parameter int NUM_CH     = 4,
   parameter int TAP_W      = 6,
   parameter int PHASE_STEP = 5,
   parameter bit SAT_FINAL  = 1'b1
) (
   input  logic [NUM_CH*TAP_W-1:0] rec_i,
   input  logic [NUM_CH-1:0]       err_i,
   output logic [NUM_CH*TAP_W-1:0] final_o
);
   localparam int MAX_TAP = (1 << TAP_W) - 1;
   localparam int SUM_W   = TAP_W + 8;

   generate
      if (PHASE_STEP * (NUM_CH - 1) >= (1 << (SUM_W - 1))) begin : g_bad_step
         $error("dcal_normalize: PHASE_STEP too large for the channel count");
      end
   endgenerate

   logic [TAP_W-1:0] ref_tap;

   always_comb begin
      logic any_ok;
      any_ok  = 1'b0;
      ref_tap = TAP_W'(MAX_TAP);
      for (int c = 0; c < NUM_CH; c++) begin
         if (!err_i[c]) begin
            any_ok = 1'b1;
            if (rec_i[c*TAP_W +: TAP_W] < ref_tap) begin
               ref_tap = rec_i[c*TAP_W +: TAP_W];
            end
         end
      end
      if (!any_ok) begin
         ref_tap = '0;
      end
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic [TAP_W-1:0] offs;
         assign offs = err_i[c] ? '0 : (rec_i[c*TAP_W +: TAP_W] - ref_tap);
         if (SAT_FINAL) begin : g_sat
            logic [SUM_W-1:0] sum;
            assign sum = SUM_W'(offs) + SUM_W'(PHASE_STEP * c);
            assign final_o[c*TAP_W +: TAP_W] =
               (sum > SUM_W'(MAX_TAP)) ? TAP_W'(MAX_TAP) : sum[TAP_W-1:0];
         end else begin : g_wrap
            assign final_o[c*TAP_W +: TAP_W] = offs + TAP_W'(PHASE_STEP * c);
         end
      end
   endgenerate

endmodule

// File: rtl/dcal_ctrl.sv
// Multi-channel input delay calibration controller (top).
module dcal_ctrl
   import dcal_pkg::*;
#(
   parameter int                NUM_CH        = 4,
   parameter int                TAP_W         = 6,
   parameter int                DATA_W        = 8,
   parameter logic [DATA_W-1:0] TRAIN_PATTERN = 8'hA5,
   parameter int                SETTLE_CYC    = 8,
   parameter int                CMP_BYTES     = 4,
   parameter int                PHASE_STEP    = 5,
   parameter bit                SAT_FINAL     = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic [NUM_CH*DATA_W-1:0] cap_data_i,
   output logic                     dly_rst_o,
   output logic [NUM_CH-1:0]        dly_inc_o,
   output logic [NUM_CH-1:0]        dly_load_o,
   output logic [NUM_CH*TAP_W-1:0]  tap_set_o,
   output logic [NUM_CH-1:0]        cal_err_o,
   output logic                     done_o
);
   localparam int MAX_TAP = (1 << TAP_W) - 1;
   localparam int CH_W    = $clog2(NUM_CH);

   generate
      if (NUM_CH < 2 || TAP_W < 2 || DATA_W < 1) begin : g_bad_cfg
         $error("dcal_ctrl: need NUM_CH >= 2, TAP_W >= 2, DATA_W >= 1");
      end
   endgenerate

   dcal_state_e             state_q;
   logic [CH_W-1:0]         ch_q;
   logic [TAP_W-1:0]        tap_q;
   logic [NUM_CH*TAP_W-1:0] rec_q;
   logic [NUM_CH-1:0]       err_q;
   logic [NUM_CH-1:0]       inc_q;
   logic                    rstp_q;
   logic [NUM_CH-1:0]       ld_q;
   logic [NUM_CH*TAP_W-1:0] final_q;
   logic                    done_q;

   logic                    restart;
   logic                    in_cmp;
   logic                    win_last;
   logic                    hit;
   logic                    at_max;
   logic                    last_ch;
   logic [NUM_CH*TAP_W-1:0] norm_taps;

   assign at_max  = tap_q == TAP_W'(MAX_TAP);
   assign last_ch = ch_q == CH_W'(NUM_CH - 1);

   dcal_window #(
      .SETTLE_CYC (SETTLE_CYC),
      .CMP_BYTES  (CMP_BYTES)
   ) u_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart),
      .in_cmp_o  (in_cmp),
      .last_o    (win_last)
   );

   dcal_match #(
      .NUM_CH        (NUM_CH),
      .DATA_W        (DATA_W),
      .TRAIN_PATTERN (TRAIN_PATTERN)
   ) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_i   (cap_data_i),
      .sel_i    (ch_q),
      .sample_i (in_cmp),
      .clear_i  (restart),
      .hit_o    (hit)
   );

   dcal_normalize #(
      .NUM_CH     (NUM_CH),
      .TAP_W      (TAP_W),
      .PHASE_STEP (PHASE_STEP),
      .SAT_FINAL  (SAT_FINAL)
   ) u_norm (
      .rec_i   (rec_q),
      .err_i   (err_q),
      .final_o (norm_taps)
   );

   always_comb begin
      restart = 1'b0;
      case (state_q)
         ST_CLEAR:   restart = 1'b1;
         ST_MEASURE: restart = win_last && !(last_ch && (hit || at_max));
         default:    restart = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ch_q    <= '0;
         tap_q   <= '0;
         rec_q   <= '0;
         err_q   <= '0;
         inc_q   <= '0;
         rstp_q  <= 1'b0;
         ld_q    <= '0;
         final_q <= '0;
         done_q  <= 1'b0;
      end else begin
         inc_q  <= '0;
         rstp_q <= 1'b0;
         ld_q   <= '0;
         case (state_q)
            ST_IDLE, ST_DONE: begin
               if (start_i) begin
                  rstp_q  <= 1'b1;
                  done_q  <= 1'b0;
                  err_q   <= '0;
                  rec_q   <= '0;
                  final_q <= '0;
                  ch_q    <= '0;
                  tap_q   <= '0;
                  state_q <= ST_CLEAR;
               end
            end
            ST_CLEAR: begin
               state_q <= ST_MEASURE;
            end
            ST_MEASURE: begin
               if (win_last) begin
                  if (hit || at_max) begin
                     if (hit) begin
                        rec_q[ch_q*TAP_W +: TAP_W] <= tap_q;
                     end else begin
                        err_q[ch_q]                <= 1'b1;
                        rec_q[ch_q*TAP_W +: TAP_W] <= '0;
                     end
                     if (last_ch) begin
                        state_q <= ST_NORM;
                     end else begin
                        ch_q  <= ch_q + 1'b1;
                        tap_q <= '0;
                     end
                  end else begin
                     tap_q <= tap_q + 1'b1;
                     inc_q <= NUM_CH'(1) << ch_q;
                  end
               end
            end
            ST_NORM: begin
               final_q <= norm_taps;
               ld_q    <= '1;
               state_q <= ST_LOAD;
            end
            ST_LOAD: begin
               done_q  <= 1'b1;
               state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign dly_rst_o  = rstp_q;
   assign dly_inc_o  = inc_q;
   assign dly_load_o = ld_q;
   assign tap_set_o  = final_q;
   assign cal_err_o  = err_q;
   assign done_o     = done_q;

endmodule

// File: rtl/dcal_ctrl_chk.sv
// Protocol checker for dcal_ctrl, attached by bind.
module dcal_ctrl_chk #(
   parameter int NUM_CH = 4,
   parameter int TAP_W  = 6
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start_i,
   input logic                    dly_rst_o,
   input logic [NUM_CH-1:0]       dly_inc_o,
   input logic [NUM_CH-1:0]       dly_load_o,
   input logic [NUM_CH*TAP_W-1:0] tap_set_o,
   input logic [NUM_CH-1:0]       cal_err_o,
   input logic                    done_o
);

   // R2
   one_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dly_inc_o));

   // R2
   no_inc_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (dly_inc_o == '0));

   // R1
   rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dly_rst_o |=> !dly_rst_o);

   // R1
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && start_i) |=> (!done_o && dly_rst_o));

   // R8
   load_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|dly_load_o) |-> (&dly_load_o));

   // R8
   load_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|dly_load_o) |=> (done_o && (dly_load_o == '0)));

   // R9
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=>
         (done_o && $stable(tap_set_o) && $stable(cal_err_o)));

endmodule

bind dcal_ctrl dcal_ctrl_chk #(
   .NUM_CH (NUM_CH),
   .TAP_W  (TAP_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .dly_rst_o  (dly_rst_o),
   .dly_inc_o  (dly_inc_o),
   .dly_load_o (dly_load_o),
   .tap_set_o  (tap_set_o),
   .cal_err_o  (cal_err_o),
   .done_o     (done_o)
);

// File: tb/dcal_ctrl_tb.sv
module dcal_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 4;
   localparam int TW         = 6;
   localparam int DW         = 8;
   localparam logic [7:0] TRAIN = 8'hA5;
   localparam int STEP       = 5;
   localparam int GAP        = 12;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start_i = 1'b0;
   logic [NCH*DW-1:0]   cap_data = '0;
   logic                dly_rst_o;
   logic [NCH-1:0]      dly_inc_o;
   logic [NCH-1:0]      dly_load_o;
   logic [NCH*TW-1:0]   tap_set_o;
   logic [NCH-1:0]      cal_err_o;
   logic                done_o;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   int fail_at [NCH];
   int mtap    [NCH];
   int inc_cnt [NCH];
   int last_ch;
   int last_cyc;
   int gap_bad;
   int order_bad;

   always #(CLK_PERIOD/2) clk = ~clk;

   dcal_ctrl dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .cap_data_i (cap_data),
      .dly_rst_o  (dly_rst_o),
      .dly_inc_o  (dly_inc_o),
      .dly_load_o (dly_load_o),
      .tap_set_o  (tap_set_o),
      .cal_err_o  (cal_err_o),
      .done_o     (done_o)
   );

   // Delay-line and deserializer model, updated away from the active edge.
   always @(negedge clk) begin
      cyc <= cyc + 1;
      for (int c = 0; c < NCH; c++) begin
         int t;
         t = mtap[c];
         if (dly_rst_o) t = 0;
         else if (dly_load_o[c]) t = int'(tap_set_o[c*TW +: TW]);
         else if (dly_inc_o[c]) begin
            t = (t + 1) % 64;
            inc_cnt[c] = inc_cnt[c] + 1;
            if (c < last_ch) order_bad++;
            if (c == last_ch && (cyc - last_cyc) != GAP) gap_bad++;
            last_ch  = c;
            last_cyc = cyc;
         end
         mtap[c] = t;
         cap_data[c*DW +: DW] <= (t >= fail_at[c] && (cyc % 3) == 0) ? ~TRAIN : TRAIN;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic run_case(input int f0, input int f1, input int f2, input int f3,
                           input bit busy_start);
      int exp_err [NCH];
      int exp_fin [NCH];
      int exp_inc [NCH];
      int ref_tap;
      int waited;
      bit any_ok;
      fail_at[0] = f0; fail_at[1] = f1; fail_at[2] = f2; fail_at[3] = f3;
      any_ok = 1'b0;
      ref_tap = 64;
      for (int c = 0; c < NCH; c++) begin
         exp_err[c] = (fail_at[c] > 63) ? 1 : 0;
         exp_inc[c] = exp_err[c] ? 63 : fail_at[c];
         if (!exp_err[c]) begin
            any_ok = 1'b1;
            if (fail_at[c] < ref_tap) ref_tap = fail_at[c];
         end
      end
      if (!any_ok) ref_tap = 0;
      for (int c = 0; c < NCH; c++) begin
         exp_fin[c] = (exp_err[c] ? 0 : fail_at[c] - ref_tap) + c * STEP;
         if (exp_fin[c] > 63) exp_fin[c] = 63;
      end
      @(negedge clk);
      #1;
      for (int c = 0; c < NCH; c++) inc_cnt[c] = 0;
      last_ch = -1; last_cyc = 0; gap_bad = 0; order_bad = 0;
      pulse_start();
      #1;
      // R1: done clears once the start is taken
      check(done_o == 1'b0 && cal_err_o == '0, "R1 clear on start", int'(done_o), 0);
      if (busy_start) begin
         repeat (200) @(negedge clk);
         pulse_start();
         #1;
         // R9: start while busy is ignored
         check(done_o == 1'b0, "R9 start ignored while busy", int'(done_o), 0);
      end
      waited = 0;
      while (!done_o && waited < 6000) begin
         @(negedge clk);
         #1;
         waited++;
      end
      // R8: done rises after the load
      check(done_o == 1'b1, "R8 done reached", int'(done_o), 1);
      for (int c = 0; c < NCH; c++) begin
         // R5 error flag
         check(int'(cal_err_o[c]) == exp_err[c], $sformatf("R5 err ch%0d", c),
               int'(cal_err_o[c]), exp_err[c]);
         // R4 R5 increments received while measuring
         check(inc_cnt[c] == exp_inc[c], $sformatf("R4 inc count ch%0d", c),
               inc_cnt[c], exp_inc[c]);
         // R6 R7 final tap
         check(int'(tap_set_o[c*TW +: TW]) == exp_fin[c], $sformatf("R7 final ch%0d", c),
               int'(tap_set_o[c*TW +: TW]), exp_fin[c]);
         // R8 delay line holds loaded value
         check(mtap[c] == exp_fin[c], $sformatf("R8 loaded ch%0d", c), mtap[c], exp_fin[c]);
      end
      // R3 increment spacing, R2 channel order
      check(gap_bad == 0, "R3 increment spacing", gap_bad, 0);
      check(order_bad == 0, "R2 channel order", order_bad, 0);
      // R9 results held while no start
      repeat (20) @(negedge clk);
      #1;
      check(done_o == 1'b1 && int'(tap_set_o[0 +: TW]) == exp_fin[0], "R9 hold",
            int'(tap_set_o[0 +: TW]), exp_fin[0]);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      for (int c = 0; c < NCH; c++) begin
         fail_at[c] = 70; mtap[c] = 0; inc_cnt[c] = 0;
      end
      last_ch = -1;
      repeat (4) @(negedge clk);
      #1;
      // R10 reset state
      check(done_o == 1'b0, "R10 done", int'(done_o), 0);
      check(tap_set_o == '0, "R10 taps", int'(tap_set_o), 0);
      check(cal_err_o == '0 && dly_inc_o == '0 && dly_load_o == '0 && !dly_rst_o,
            "R10 controls", int'(cal_err_o), 0);
      rst_n = 1'b1;
      // R6 R7 explicit corners
      run_case(0, 10, 20, 60, 1'b0);   // R7 saturation on channel 3
      run_case(20, 70, 30, 25, 1'b0);  // R6 error channel excluded from minimum
      run_case(70, 70, 70, 70, 1'b0);  // R5 all channels never fail
      run_case(0, 0, 0, 0, 1'b0);      // R4 failure at tap 0
      run_case(63, 40, 63, 50, 1'b0);  // R4 failure at the last tap
      run_case(30, 33, 31, 35, 1'b1);  // R9 start during calibration
      // Sweep of failing taps
      for (int s = 0; s < 12; s++) begin
         run_case((s*11 + 3) % 72, (s*11 + 20) % 72, (s*11 + 37) % 72,
                  (s*11 + 54) % 72, 1'b0);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule